// File: doc/BRIEF.md
# Split-Transaction Tag Tracker

This block sits on the initiator side of a split request/response link. The initiator can issue new requests while earlier ones are still waiting for an answer. Each accepted request takes a tag from a pool of free tags. The block stores a small context word for that request, such as an address or an opcode, in a table indexed by the tag. The initiator sends the tag out with its request. The responder returns the same tag with its response. The tracker uses that tag to find the stored context again, hands the context back, and returns the tag to the pool.

The block has two checking modes, chosen by a mode input. In tagged mode, responses may come back in any order and are matched only by tag. In ordered mode, responses must come back in the order of their requests. A small FIFO of issued tags gives the tag that is expected next. A response carrying any other outstanding tag is reported as an order error.

In both modes, a response whose tag is not outstanding is reported as an unexpected-tag error. A response that is rejected with either error leaves the tracker's state unchanged. The mode input may only change while no request is outstanding.

Top module: `tagtrk`

## Requirements
- R1: After reset every tag is free, `req_ready` is high, `req_tag` is 0, and no result pulse (`match_valid`, `err_unexp`, `err_order`) is asserted.
- R2: `req_tag` always presents the lowest-numbered free tag. A request handshake (`req_valid` and `req_ready` both high at a clock edge) makes that tag outstanding and stores `req_ctx` against it.
- R3: When all `NUM_TAGS` tags are outstanding, `req_ready` is low, and a request presented in that cycle is not taken.
- R4: In tagged mode (`ordered_i` = 0), a response carrying an outstanding tag is accepted in any order. In the next cycle, `match_valid` pulses with `res_tag` equal to that tag and `match_ctx` equal to the context stored for it.
- R5: In ordered mode (`ordered_i` = 1), a response is accepted only if its tag is the oldest outstanding one, and it then reports a match as in R4. A response with any other outstanding tag raises `err_order` in the next cycle, reports that tag on `res_tag`, and frees nothing.
- R6: A response whose tag is not outstanding raises `err_unexp` in the next cycle, with that tag on `res_tag`. It changes no state: tag allocation and later matches behave as if the response had not arrived.
- R7: A tag is freed at the clock edge that accepts its response, and it can be issued again from the next cycle on. A request in the same cycle as that response receives a different tag.
- R8: `rsp_ready` is always high. Each response produces exactly one one-cycle result pulse in the following cycle, and no pulse appears in a cycle that follows no response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ordered_i | input | 1 | 1 = responses must follow request order; 0 = any order, matched by tag |
| req_valid | input | 1 | Initiator offers a request |
| req_ready | output | 1 | A free tag exists, so a request can be taken |
| req_ctx | input | CTX_W | Context word to keep with the request |
| req_tag | output | TAG_W | Tag assigned to the offered request |
| rsp_valid | input | 1 | Response present |
| rsp_ready | output | 1 | Always 1: responses are never stalled |
| rsp_tag | input | TAG_W | Tag carried by the response |
| match_valid | output | 1 | One-cycle pulse: the response was matched |
| res_tag | output | TAG_W | Tag of the response just judged |
| match_ctx | output | CTX_W | Context stored for the matched tag |
| err_unexp | output | 1 | One-cycle pulse: the response tag was not outstanding |
| err_order | output | 1 | One-cycle pulse: in ordered mode, the response was not the oldest outstanding one |

## Verification
In tagged mode, the pool is filled and then drained in a scrambled order. This separates true lookup by tag from a design that simply returns contexts oldest first. The full pool also shows that a request offered while no tag is free is refused.

A stale response sent after its tag was already freed exercises the unexpected-tag path. Later allocations show that the rejected response disturbed nothing. Cycles in which a request and a response overlap, followed by a request that receives the tag freed one cycle earlier, pin down when a tag is released.

In ordered mode, out-of-turn responses and a response for a tag that is not outstanding are mixed in among correct ones. Each of them must leave the order FIFO intact, so that later in-order responses still match.

// File: rtl/tagtrk_pkg.sv
package tagtrk_pkg;
   // Outcome of judging one response
   typedef enum logic [1:0] {
      RES_NONE  = 2'd0,
      RES_MATCH = 2'd1,
      RES_UNEXP = 2'd2,
      RES_ORDER = 2'd3
   } rsp_res_e;
endpackage

// File: rtl/tagtrk_alloc.sv
module tagtrk_alloc #(
   parameter int NUM_TAGS = 4,
   localparam int TAG_W = $clog2(NUM_TAGS)
) (
   input  logic [NUM_TAGS-1:0] busy_i,
   output logic                any_free_o,
   output logic [TAG_W-1:0]    free_tag_o
);
   // Scan from the top down so the lowest free index wins
   always_comb begin
      any_free_o = 1'b0;
      free_tag_o = '0;
      for (int i = NUM_TAGS - 1; i >= 0; i--) begin
         if (!busy_i[i]) begin
            any_free_o = 1'b1;
            free_tag_o = TAG_W'(i);
         end
      end
   end
endmodule

// File: rtl/tagtrk_order_fifo.sv
module tagtrk_order_fifo #(
   parameter int DEPTH = 4,
   parameter int TAG_W = 2,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             push_i,
   input  logic [TAG_W-1:0] push_tag_i,
   input  logic             pop_i,
   output logic [TAG_W-1:0] head_tag_o,
   output logic [CNT_W-1:0] count_o
);
   logic [TAG_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;

   function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (push_i) mem[wr_ptr] <= push_tag_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear_i) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         count_o <= '0;
      end else begin
         if (push_i) wr_ptr <= step_ptr(wr_ptr);
         if (pop_i)  rd_ptr <= step_ptr(rd_ptr);
         case ({push_i, pop_i})
            2'b10:   count_o <= count_o + 1'b1;
            2'b01:   count_o <= count_o - 1'b1;
            default: count_o <= count_o;
         endcase
      end
   end

   assign head_tag_o = mem[rd_ptr];

   // R3
   fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !pop_i && !clear_i) |-> (count_o < CNT_W'(DEPTH)));

   // R5
   fifo_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && !clear_i) |-> (count_o != '0));
endmodule

// File: rtl/tagtrk.sv
module tagtrk #(
   parameter int NUM_TAGS = 4,
   parameter int CTX_W    = 8,
   localparam int TAG_W   = $clog2(NUM_TAGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ordered_i,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [CTX_W-1:0] req_ctx,
   output logic [TAG_W-1:0] req_tag,
   input  logic             rsp_valid,
   output logic             rsp_ready,
   input  logic [TAG_W-1:0] rsp_tag,
   output logic             match_valid,
   output logic [TAG_W-1:0] res_tag,
   output logic [CTX_W-1:0] match_ctx,
   output logic             err_unexp,
   output logic             err_order
);
   import tagtrk_pkg::*;

   localparam int CNT_W = $clog2(NUM_TAGS + 1);

   generate
      if (NUM_TAGS < 2) begin : g_bad_tags
         $error("tagtrk: NUM_TAGS must be at least 2");
      end
      if (CTX_W < 1) begin : g_bad_ctx
         $error("tagtrk: CTX_W must be at least 1");
      end
   endgenerate

   logic [NUM_TAGS-1:0] busy_q;
   logic [CTX_W-1:0]    ctx_mem [NUM_TAGS];
   logic [TAG_W-1:0]    head_tag;
   logic [CNT_W-1:0]    fifo_cnt;
   logic                any_free;
   logic [TAG_W-1:0]    free_tag;
   logic                req_fire, tag_hit, in_turn, accept;
   rsp_res_e            res_d, res_q;
   logic [TAG_W-1:0]    res_tag_q;
   logic [CTX_W-1:0]    ctx_q;

   tagtrk_alloc #(.NUM_TAGS(NUM_TAGS)) u_alloc (
      .busy_i     (busy_q),
      .any_free_o (any_free),
      .free_tag_o (free_tag)
   );

   tagtrk_order_fifo #(.DEPTH(NUM_TAGS), .TAG_W(TAG_W)) u_fifo (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear_i    (!ordered_i),
      .push_i     (req_fire && ordered_i),
      .push_tag_i (free_tag),
      .pop_i      (accept && ordered_i),
      .head_tag_o (head_tag),
      .count_o    (fifo_cnt)
   );

   assign req_ready = any_free;
   assign req_tag   = free_tag;
   assign rsp_ready = 1'b1;
   assign req_fire  = req_valid && any_free;

   // A tag beyond NUM_TAGS-1 is never outstanding
   assign tag_hit = ({1'b0, rsp_tag} < (TAG_W + 1)'(NUM_TAGS)) && busy_q[rsp_tag];
   assign in_turn = !ordered_i || (head_tag == rsp_tag);

   always_comb begin
      if (!rsp_valid)     res_d = RES_NONE;
      else if (!tag_hit)  res_d = RES_UNEXP;
      else if (!in_turn)  res_d = RES_ORDER;
      else                res_d = RES_MATCH;
   end
   assign accept = (res_d == RES_MATCH);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= '0;
      end else begin
         for (int i = 0; i < NUM_TAGS; i++) begin
            if (req_fire && free_tag == TAG_W'(i))   busy_q[i] <= 1'b1;
            else if (accept && rsp_tag == TAG_W'(i)) busy_q[i] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (req_fire) ctx_mem[free_tag] <= req_ctx;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_q     <= RES_NONE;
         res_tag_q <= '0;
         ctx_q     <= '0;
      end else begin
         res_q     <= res_d;
         res_tag_q <= rsp_tag;
         ctx_q     <= accept ? ctx_mem[rsp_tag] : '0;
      end
   end

   assign match_valid = (res_q == RES_MATCH);
   assign err_unexp   = (res_q == RES_UNEXP);
   assign err_order   = (res_q == RES_ORDER);
   assign res_tag     = res_tag_q;
   assign match_ctx   = ctx_q;

   // R2
   no_double_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |-> !busy_q[req_tag]);

   // R8
   pulse_needs_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (match_valid || err_unexp || err_order) |-> $past(rsp_valid));

   // R6
   unexp_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !tag_hit && !req_fire) |=> $stable(busy_q));

   // R7
   freed_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !busy_q[$past(rsp_tag)]);

   // R5
   fifo_tracks_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ordered_i && $past(ordered_i)) |-> (int'(fifo_cnt) == $countones(busy_q)));
endmodule

// File: tb/tagtrk_test.sv
module tagtrk_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ordered_i = 1'b0;
   logic       req_valid = 1'b0;
   logic       req_ready;
   logic [7:0] req_ctx = '0;
   logic [1:0] req_tag;
   logic       rsp_valid = 1'b0;
   logic       rsp_ready;
   logic [1:0] rsp_tag = '0;
   logic       match_valid;
   logic [1:0] res_tag;
   logic [7:0] match_ctx;
   logic       err_unexp, err_order;

   int checks = 0;
   int failures = 0;
   bit started = 1'b0;
   bit done = 1'b0;

   typedef struct {
      int    kind;   // 0 none, 1 match, 2 unexpected, 3 order
      int    tag;
      int    ctx;
      string req;
   } exp_t;
   exp_t expq[$];

   bit       mbusy [4];
   int       mctx [4];
   int       mfifo[$];
   bit       mord = 1'b0;

   always #5 clk = ~clk;

   tagtrk #(.NUM_TAGS(4), .CTX_W(8)) uut (
      .clk(clk), .rst_n(rst_n), .ordered_i(ordered_i),
      .req_valid(req_valid), .req_ready(req_ready), .req_ctx(req_ctx), .req_tag(req_tag),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_tag(rsp_tag),
      .match_valid(match_valid), .res_tag(res_tag), .match_ctx(match_ctx),
      .err_unexp(err_unexp), .err_order(err_order)
   );

   task automatic check(input bit ok, input string r, input string what);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s: %s", r, what);
      end
   endtask

   // Driver: one cycle of stimulus, with expectations from the model
   task automatic step(input bit rv, input logic [7:0] c, input bit sv, input logic [1:0] t);
      exp_t e;
      int   lf;
      bit   anyf;
      @(negedge clk);
      ordered_i = mord;
      req_valid = rv; req_ctx = c; rsp_valid = sv; rsp_tag = t;
      #1;
      anyf = 1'b0; lf = 0;
      for (int i = 3; i >= 0; i--) if (!mbusy[i]) begin anyf = 1'b1; lf = i; end
      check(req_ready === anyf, anyf ? "R2" : "R3",
            $sformatf("req_ready actual=%0b expected=%0b", req_ready, anyf));
      if (anyf)
         check(req_tag === 2'(lf), "R2",
               $sformatf("req_tag actual=%0d expected=%0d", req_tag, lf));
      check(rsp_ready === 1'b1, "R8",
            $sformatf("rsp_ready actual=%0b expected=1", rsp_ready));
      e.kind = 0; e.tag = int'(t); e.ctx = 0; e.req = "R8";
      if (sv) begin
         if (!mbusy[t]) begin
            e.kind = 2; e.req = "R6";
         end else if (mord && mfifo[0] != int'(t)) begin
            e.kind = 3; e.req = "R5";
         end else begin
            e.kind = 1; e.ctx = mctx[t]; e.req = mord ? "R5" : "R4";
            mbusy[t] = 1'b0;
            if (mord) void'(mfifo.pop_front());
         end
      end
      if (rv && anyf) begin
         mbusy[lf] = 1'b1; mctx[lf] = int'(c);
         if (mord) mfifo.push_back(lf);
      end
      expq.push_back(e);
      @(posedge clk);
   endtask

   // Monitor: compare each registered result against the scoreboard
   always @(negedge clk) begin
      if (started && expq.size() > 0) begin
         exp_t e;
         e = expq.pop_front();
         check(match_valid === (e.kind == 1) && err_unexp === (e.kind == 2) &&
               err_order === (e.kind == 3), e.req,
               $sformatf("pulses m/u/o actual=%0b%0b%0b expected kind=%0d",
                         match_valid, err_unexp, err_order, e.kind));
         if (e.kind != 0)
            check(res_tag === 2'(e.tag), e.req,
                  $sformatf("res_tag actual=%0d expected=%0d", res_tag, e.tag));
         if (e.kind == 1)
            check(match_ctx === 8'(e.ctx), e.req,
                  $sformatf("match_ctx actual=%0h expected=%0h", match_ctx, e.ctx));
      end
   end

   initial begin
      #2_000_000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(req_ready === 1'b1, "R1", $sformatf("req_ready actual=%0b expected=1", req_ready));
      check(req_tag === 2'd0, "R1", $sformatf("req_tag actual=%0d expected=0", req_tag));
      check({match_valid, err_unexp, err_order} === 3'b000, "R1",
            $sformatf("pulses actual=%0b%0b%0b expected=000", match_valid, err_unexp, err_order));
      started = 1'b1;

      // Tagged mode: fill, refuse when full, drain out of order
      mord = 1'b0;
      step(1, 8'h10, 0, 0);
      step(1, 8'h11, 0, 0);
      step(1, 8'h12, 0, 0);
      step(1, 8'h13, 0, 0);
      step(1, 8'h14, 0, 0);   // R3 pool full
      step(0, 8'h00, 1, 2);   // R4
      step(0, 8'h00, 1, 0);
      step(0, 8'h00, 1, 2);   // R6 stale tag
      step(1, 8'h20, 1, 3);   // R7 overlap
      step(1, 8'h21, 0, 0);
      step(1, 8'h22, 1, 1);
      step(1, 8'h23, 0, 0);   // R7 tag freed one cycle earlier
      step(0, 8'h00, 1, 3);
      step(0, 8'h00, 1, 0);
      step(0, 8'h00, 1, 1);
      step(0, 8'h00, 1, 2);
      step(0, 8'h00, 0, 0);

      // Ordered mode
      mord = 1'b1;
      step(0, 8'h00, 0, 0);
      step(1, 8'h30, 0, 0);
      step(1, 8'h31, 0, 0);
      step(1, 8'h32, 0, 0);
      step(0, 8'h00, 1, 1);   // R5 out of turn
      step(0, 8'h00, 1, 3);   // R6
      step(0, 8'h00, 1, 0);   // R5 in turn
      step(1, 8'h33, 1, 2);   // R5 out of turn with request
      step(0, 8'h00, 1, 1);
      step(1, 8'h34, 1, 2);
      step(0, 8'h00, 1, 0);
      step(0, 8'h00, 1, 1);
      step(0, 8'h00, 0, 0);
      step(0, 8'h00, 0, 0);
      @(negedge clk);
      #1;
      check(expq.size() == 0, "R8",
            $sformatf("pending results actual=%0d expected=0", expq.size()));
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule